// File: doc/BRIEF.md
# Inter-Core Mailbox Doorbell Unit

This unit gives every core of a small cluster four 32-bit mailboxes. Cores use them to raise inter-processor interrupts on each other. A core rings another core by writing ones into one of that core's mailboxes through a set view. The owning core reads the mailbox to learn which doorbells fired, then acknowledges them through a clear view of the same storage.

Each core has its own enable register. Any mailbox that is nonzero and enabled raises a request line toward the local interrupt router. The request lines are also folded into one summary line per core.

Several bus requesters can access the register file in the same cycle, typically one port per core. Each port is a simple 32-bit word register interface with separate write and read strobes. Read data is registered and belongs to its own port. Reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `mbx_doorbell`

## Requirements
- R1: After reset every mailbox, every enable register, every pending line, every summary line and every port's read data are zero.
- R2: A write of value V to the set view at byte address 0x40 + 16*c + 4*m sets every bit that is one in V in mailbox m of core c. Bits written as zero keep their value.
- R3: A read of the clear view at byte address 0x80 + 16*c + 4*m returns mailbox m of core c. A write of V there clears exactly the bits that are one in V.
- R4: Reads of the set view return zero. Addresses 0xC0 to 0xFF and any address whose two low bits are nonzero are unmapped: they read as zero and writes to them change nothing.
- R5: The enable register of core c lies at byte address 4*c. Bit m (m = 0..3) enables mailbox m of that core. Written bits 31:4 are dropped and read back as zero.
- R6: Pending line mbox_pend[4*c + m] is high exactly when mailbox m of core c is nonzero and its enable bit is set. core_irq[c] is the OR of that core's four pending lines.
- R7: If one port sets a bit and another port clears the same bit in the same cycle, the bit ends up set.
- R8: If several ports write the same enable register in one cycle, the value from the lowest-numbered port is stored.
- R9: Read data appears on a port's bus_rdata slice in the cycle after its read strobe and holds until that port reads again. Reads on other ports do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | NUM_PORTS | Write strobe per port |
| bus_rd | input | NUM_PORTS | Read strobe per port |
| bus_addr | input | NUM_PORTS*ADDR_W | Byte address per port, port p at bits p*ADDR_W upward |
| bus_wdata | input | NUM_PORTS*32 | Write data per port |
| bus_rdata | output | NUM_PORTS*32 | Registered read data per port |
| mbox_pend | output | NUM_CORES*4 | Per-mailbox request, bit 4*c + m |
| core_irq | output | NUM_CORES | Per-core OR of its mailbox requests |

## Verification
The bench provokes a set and a clear that hit one bit in the same cycle. A design with clear priority would lose that doorbell and read back zero instead of one. It writes all ones to an enable register to catch a design that stores or returns bits above the four mailboxes. It also aims at misaligned and unmapped addresses, which a loose decoder would alias onto mailbox 0. Finally it makes two ports write one enable register together, where a wrong priority shows up as the other port's value, and it applies reset in the middle of a run to confirm the pending lines drop at once.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Mailboxes per core; the 16-byte per-core stride follows from this.
  localparam int MBOX_PER_CORE = 4;
  localparam int MB_W          = 2;
  localparam int WORD_W        = 32;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_EN   = 2'd1,
    KIND_SET  = 2'd2,
    KIND_CLR  = 2'd3
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e        kind;
    logic [7:0]       core;
    logic [MB_W-1:0]  mbox;
  } reg_dec_t;
endpackage

// File: rtl/mbx_addr_decode.sv
module mbx_addr_decode
  import mbx_pkg::*;
#(
  parameter int NUM_CORES = 4,   // power of two
  parameter int ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_dec_t          dec
);
  localparam int WIN_B = NUM_CORES * MBOX_PER_CORE * 4;
  localparam int WIN_W = $clog2(WIN_B);

  logic [ADDR_W-1:0] region;
  logic [WIN_W-3:0]  word_idx;

  assign region   = addr >> WIN_W;
  assign word_idx = addr[WIN_W-1:2];

  always_comb begin
    dec      = '0;
    dec.kind = KIND_NONE;
    if (addr[1:0] == 2'b00) begin
      if (region == '0) begin
        if (int'(word_idx) < NUM_CORES) begin
          dec.kind = KIND_EN;
          dec.core = 8'(word_idx);
        end
      end else if (region == ADDR_W'(1)) begin
        dec.kind = KIND_SET;
        dec.core = 8'(word_idx >> MB_W);
        dec.mbox = word_idx[MB_W-1:0];
      end else if (region == ADDR_W'(2)) begin
        dec.kind = KIND_CLR;
        dec.core = 8'(word_idx >> MB_W);
        dec.mbox = word_idx[MB_W-1:0];
      end
    end
  end
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         q_en;

  always_comb begin
    q_en  = (|set_mask) | (|clr_mask);
    q_nxt = (q & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> ((q & $past(set_mask)) == $past(set_mask)));

  // R3
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_mask & ~set_mask) != '0) |=> ((q & $past(clr_mask & ~set_mask)) == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask == '0 && clr_mask == '0) |=> $stable(q));
endmodule

// File: rtl/mbx_enable_bank.sv
module mbx_enable_bank #(
  parameter int NUM_PORTS = 2,
  parameter int W         = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_PORTS-1:0]   wr_hit,
  input  logic [NUM_PORTS*W-1:0] wr_data,
  output logic [W-1:0]           q
);
  logic [W-1:0] q_nxt;
  logic         q_en;

  always_comb begin
    q_nxt = q;
    q_en  = 1'b0;
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (wr_hit[p]) begin
        q_nxt = wr_data[p*W +: W];
        q_en  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

  // R8
  port0_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[0] |=> (q == $past(wr_data[W-1:0])));

  // R5
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit == '0) |=> $stable(q));
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
  import mbx_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PORTS-1:0]          bus_wr,
  input  logic [NUM_PORTS-1:0]          bus_rd,
  input  logic [NUM_PORTS*ADDR_W-1:0]   bus_addr,
  input  logic [NUM_PORTS*WORD_W-1:0]   bus_wdata,
  output logic [NUM_PORTS*WORD_W-1:0]   bus_rdata,
  output logic [NUM_CORES*MBOX_PER_CORE-1:0] mbox_pend,
  output logic [NUM_CORES-1:0]          core_irq
);
  localparam int NSLOT = NUM_CORES * MBOX_PER_CORE;

  // Reset: asserted asynchronously, released after two clock edges
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  // Per-port address decode
  reg_dec_t dec [NUM_PORTS];
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
    mbx_addr_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr[p*ADDR_W +: ADDR_W]),
      .dec  (dec[p])
    );
  end

  // Mailbox storage
  logic [WORD_W-1:0] set_m [NSLOT];
  logic [WORD_W-1:0] clr_m [NSLOT];
  logic [WORD_W-1:0] mb_q  [NSLOT];

  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      set_m[s] = '0;
      clr_m[s] = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (bus_wr[p] &&
            (int'(dec[p].core) * MBOX_PER_CORE + int'(dec[p].mbox)) == s) begin
          if (dec[p].kind == KIND_SET) set_m[s] = set_m[s] | bus_wdata[p*WORD_W +: WORD_W];
          if (dec[p].kind == KIND_CLR) clr_m[s] = clr_m[s] | bus_wdata[p*WORD_W +: WORD_W];
        end
      end
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    mbx_slot #(.W(WORD_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_q),
      .set_mask (set_m[s]),
      .clr_mask (clr_m[s]),
      .q        (mb_q[s])
    );
  end

  // Per-core enable registers
  logic [MBOX_PER_CORE-1:0] en_q [NUM_CORES];
  logic [NUM_PORTS*MBOX_PER_CORE-1:0] en_wdata;

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++)
      en_wdata[p*MBOX_PER_CORE +: MBOX_PER_CORE] = bus_wdata[p*WORD_W +: MBOX_PER_CORE];
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_en
    logic [NUM_PORTS-1:0] hit;
    always_comb begin
      for (int p = 0; p < NUM_PORTS; p++)
        hit[p] = bus_wr[p] && dec[p].kind == KIND_EN && int'(dec[p].core) == c;
    end
    mbx_enable_bank #(.NUM_PORTS(NUM_PORTS), .W(MBOX_PER_CORE)) u_en (
      .clk     (clk),
      .rst_n   (rst_q),
      .wr_hit  (hit),
      .wr_data (en_wdata),
      .q       (en_q[c])
    );

    for (genvar m = 0; m < MBOX_PER_CORE; m++) begin : g_pend
      assign mbox_pend[c*MBOX_PER_CORE + m] =
        en_q[c][m] && (mb_q[c*MBOX_PER_CORE + m] != '0);
    end
    assign core_irq[c] = |mbox_pend[c*MBOX_PER_CORE +: MBOX_PER_CORE];
  end

  // Registered read data per port
  logic [WORD_W-1:0] rd_nxt [NUM_PORTS];
  logic [WORD_W-1:0] rd_q   [NUM_PORTS];

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      rd_nxt[p] = '0;
      case (dec[p].kind)
        KIND_EN:  rd_nxt[p] = WORD_W'(en_q[int'(dec[p].core)]);
        KIND_CLR: rd_nxt[p] = mb_q[int'(dec[p].core) * MBOX_PER_CORE + int'(dec[p].mbox)];
        default:  rd_nxt[p] = '0;
      endcase
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q)         rd_q[p] <= '0;
      else if (bus_rd[p]) rd_q[p] <= rd_nxt[p];
    end
    assign bus_rdata[p*WORD_W +: WORD_W] = rd_q[p];

    // R4
    set_view_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (bus_rd[p] && dec[p].kind == KIND_SET) |=> (bus_rdata[p*WORD_W +: WORD_W] == '0));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
      !bus_rd[p] |=> $stable(bus_rdata[p*WORD_W +: WORD_W]));
  end

  // R6
  irq_matches_pend_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (core_irq != '0) |-> (mbox_pend != '0));
endmodule

// File: tb/mbx_doorbell_bench.sv
module mbx_doorbell_bench;
  localparam int NC = 4;
  localparam int NP = 2;
  localparam int AW = 8;
  localparam int NV = 21;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NP-1:0]   bus_wr, bus_rd;
  logic [NP*AW-1:0] bus_addr;
  logic [NP*32-1:0] bus_wdata;
  logic [NP*32-1:0] bus_rdata;
  logic [NC*4-1:0] mbox_pend;
  logic [NC-1:0]   core_irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  mbx_doorbell #(.NUM_CORES(NC), .NUM_PORTS(NP), .ADDR_W(AW)) u_mbx_doorbell (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
    .mbox_pend, .core_irq
  );

  // {is_rd, port, addr, wdata, exp_rdata, exp_pend}
  localparam logic [89:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h80, 32'h0,        32'h0,        16'h0000}, // R1 R3
    {1'b0, 1'b0, 8'h40, 32'h5,        32'h0,        16'h0000}, // R2 R6
    {1'b1, 1'b0, 8'h80, 32'h0,        32'h5,        16'h0000}, // R2 R3
    {1'b1, 1'b0, 8'h40, 32'h0,        32'h0,        16'h0000}, // R4
    {1'b0, 1'b0, 8'h00, 32'h1,        32'h0,        16'h0001}, // R5 R6
    {1'b1, 1'b0, 8'h00, 32'h0,        32'h1,        16'h0001}, // R5
    {1'b0, 1'b0, 8'h40, 32'h80000000, 32'h0,        16'h0001}, // R2
    {1'b0, 1'b0, 8'h80, 32'h5,        32'h0,        16'h0001}, // R3
    {1'b1, 1'b0, 8'h80, 32'h0,        32'h80000000, 16'h0001}, // R3
    {1'b0, 1'b0, 8'h80, 32'h80000000, 32'h0,        16'h0000}, // R3 R6
    {1'b0, 1'b0, 8'h6C, 32'h10,       32'h0,        16'h0000}, // R2 R6
    {1'b0, 1'b0, 8'h08, 32'hF,        32'h0,        16'h0800}, // R5 R6
    {1'b0, 1'b1, 8'h74, 32'h1,        32'h0,        16'h0800}, // R2 R6
    {1'b1, 1'b1, 8'hB4, 32'h0,        32'h1,        16'h0800}, // R3 R9
    {1'b0, 1'b0, 8'h00, 32'hFFFFFFFE, 32'h0,        16'h0800}, // R5
    {1'b1, 1'b0, 8'h00, 32'h0,        32'hE,        16'h0800}, // R5
    {1'b0, 1'b0, 8'hC0, 32'hFFFF,     32'h0,        16'h0800}, // R4
    {1'b1, 1'b0, 8'hC0, 32'h0,        32'h0,        16'h0800}, // R4
    {1'b0, 1'b0, 8'h41, 32'h1,        32'h0,        16'h0800}, // R4
    {1'b1, 1'b0, 8'h80, 32'h0,        32'h0,        16'h0800}, // R4
    {1'b0, 1'b0, 8'hAC, 32'h10,       32'h0,        16'h0000}  // R3 R6
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    bus_wr = '0; bus_rd = '0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic drive(input int p, input logic rd, input logic [7:0] a, input logic [31:0] d);
    bus_wr[p] = !rd;
    bus_rd[p] = rd;
    bus_addr[p*AW +: AW] = a;
    bus_wdata[p*32 +: 32] = d;
  endtask

  function automatic logic [31:0] irq_of(input logic [15:0] pend);
    logic [31:0] r = '0;
    for (int c = 0; c < NC; c++) r[c] = |pend[c*4 +: 4];
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pend", 32'(mbox_pend), 32'h0);
    chk("R1 irq", 32'(core_irq), 32'h0);
    chk("R1 rdata p0", bus_rdata[31:0], 32'h0);
    chk("R1 rdata p1", bus_rdata[63:32], 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic        v_rd;
      logic        v_port;
      logic [7:0]  v_addr;
      logic [31:0] v_wd, v_exp;
      logic [15:0] v_pend;
      {v_rd, v_port, v_addr, v_wd, v_exp, v_pend} = VEC[i];
      idle();
      drive(int'(v_port), v_rd, v_addr, v_wd);
      @(negedge clk);
      if (v_rd) chk($sformatf("R3/R4/R5/R9 vec%0d rdata", i),
                    bus_rdata[int'(v_port)*32 +: 32], v_exp);
      chk($sformatf("R6 vec%0d pend", i), 32'(mbox_pend), 32'(v_pend));
      chk($sformatf("R6 vec%0d irq", i), 32'(core_irq), irq_of(v_pend));
    end
    idle();
    @(negedge clk);
    // R9: port 1 read data untouched by later port 0 reads
    chk("R9 port1 hold", bus_rdata[63:32], 32'h1);

    // R7: set and clear on the same bit in one cycle
    drive(0, 1'b0, 8'h40, 32'h3);
    @(negedge clk); idle();
    drive(0, 1'b0, 8'h80, 32'h3);
    drive(1, 1'b0, 8'h40, 32'h1);
    @(negedge clk); idle();
    drive(0, 1'b1, 8'h80, 32'h0);
    @(negedge clk); idle();
    chk("R7 set wins", bus_rdata[31:0], 32'h1);

    // R8: two ports write one enable register together
    drive(0, 1'b0, 8'h04, 32'h1);
    drive(1, 1'b0, 8'h04, 32'h2);
    @(negedge clk); idle();
    drive(1, 1'b1, 8'h04, 32'h0);
    @(negedge clk); idle();
    chk("R8 low port wins", bus_rdata[63:32], 32'h1);

    // R1: reset in mid-run
    drive(0, 1'b0, 8'h00, 32'h1);
    @(negedge clk); idle();
    chk("R6 pend before reset", 32'(mbox_pend), 32'h0001);
    rst_n = 1'b0;
    #2;
    chk("R1 pend async clear", 32'(mbox_pend), 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(0, 1'b1, 8'h80, 32'h0);
    drive(1, 1'b1, 8'h00, 32'h0);
    @(negedge clk); idle();
    chk("R1 mailbox after reset", bus_rdata[31:0], 32'h0);
    chk("R1 enable after reset", bus_rdata[63:32], 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule